// File: doc/BRIEF.md
# Deferred Interrupt Queue

This block collects interrupt requests from several lines and keeps them in a circular queue until a single, non-preemptive CPU can take them. A rising edge on a request line logs one queue entry that holds that line's index. Entries are kept in the order in which they arrived. When several lines rise in the same cycle, they are logged one per cycle, lowest index first.

The CPU sees one interrupt line and the index of the oldest queued entry beside it. The CPU acknowledges to take the entry. That removes it from the queue and marks the CPU as busy in a handler. A return strobe ends the handler, and any entry still queued is presented on the very next cycle.

A request that finds the queue full is dropped and sets a sticky overflow flag. Software clears that flag with a one-cycle strobe.

Top module: `irq_fifo_queue`

## Requirements
- R1: After reset, irq_o is 0, ovf_o is 0 and the queue is empty.
- R2: A 0-to-1 transition on req_i[k] logs exactly one entry with value k. A line held high logs nothing further until it falls and rises again.
- R3: Lines rising in the same cycle are logged one per clock cycle in ascending index order. The first is written on the clock edge that samples the rise.
- R4: Entries are served in the order they were logged (first in, first out), whatever their index.
- R5: irq_o is 1 exactly when the queue is non-empty and no handler is active. irq_id_o then shows the index of the oldest entry, starting the cycle after that entry is written.
- R6: ack_i while irq_o is 1 removes the oldest entry and starts a handler. irq_o then stays 0 until ret_i.
- R7: If entries remain when ret_i ends a handler, irq_o is 1 in the following cycle.
- R8: While irq_o is 1 and ack_i is 0, irq_id_o does not change.
- R9: The queue holds DEPTH entries. A request logged while the queue holds DEPTH entries is dropped and sets ovf_o. ovf_o stays set, and the stored entries are served unchanged.
- R10: ovf_clr_i clears ovf_o on the next edge. A new overflow in the same cycle keeps it set.
- R11: ack_i while irq_o is 0 has no effect: a later request is still presented at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request lines, rising edge logs an entry |
| irq_o | output | 1 | Interrupt to the CPU |
| irq_id_o | output | $clog2(N_SRC) | Index of the oldest queued request |
| ack_i | input | 1 | CPU takes the presented entry |
| ret_i | input | 1 | CPU leaves its handler |
| ovf_o | output | 1 | Sticky queue overflow flag |
| ovf_clr_i | input | 1 | Clears ovf_o |

## Verification
The main flow is driven with single-line pulses, with sparse and dense multi-line bursts, and with a line held high for several cycles.
- The single-line pulses show where an entry's index lands.
- The bursts separate ascending same-cycle logging from arrival-order service.
- The held line separates edge capture from level capture.

A high-index line followed later by a low-index line shows first-in-first-out service rather than priority by index. Three full bursts without service fill the queue past its depth, which shows that dropped requests leave the earlier eight entries intact and the flag sticky.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
  typedef enum logic {HS_FREE = 1'b0, HS_BUSY = 1'b1} hs_state_e;
endpackage

// File: rtl/irqq_capture.sv
module irqq_capture #(
  parameter int N_SRC = 4,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic             wr_valid_o,
  output logic [SRC_W-1:0] wr_id_o
);
  logic [N_SRC-1:0] req_q, hold_q, pend, pick;

  always_comb begin
    pend = hold_q | (req_i & ~req_q);
    pick = '0;
    wr_id_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (pend[k]) begin
        pick = '0;
        pick[k] = 1'b1;
        wr_id_o = SRC_W'(k);
      end
    end
    wr_valid_o = |pend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      hold_q <= '0;
    end else begin
      req_q  <= req_i;
      hold_q <= pend & ~pick;
    end
  end
endmodule

// File: rtl/irqq_ring.sv
module irqq_ring #(
  parameter int DEPTH = 8,
  parameter int SRC_W = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [SRC_W-1:0] wr_id_i,
  input  logic             pop_i,
  input  logic             ovf_clr_i,
  output logic [SRC_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o
);
  logic [SRC_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]   wr_ptr_q, rd_ptr_q;
  logic             do_wr, do_drop;

  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[PTR_W] != rd_ptr_q[PTR_W]) &&
                   (wr_ptr_q[PTR_W-1:0] == rd_ptr_q[PTR_W-1:0]);
  assign do_wr   = wr_valid_i && !full_o;
  assign do_drop = wr_valid_i && full_o;
  assign head_o  = mem_q[rd_ptr_q[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      ovf_o    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_wr) begin
        mem_q[wr_ptr_q[PTR_W-1:0]] <= wr_id_i;
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
      if (pop_i && !empty_o) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_drop)        ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irqq_deliver.sv
module irqq_deliver
  import irqq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic ack_i,
  input  logic ret_i,
  output logic irq_o,
  output logic pop_o,
  output logic busy_o
);
  hs_state_e st_q;

  assign busy_o = (st_q == HS_BUSY);
  assign irq_o  = !empty_i && !busy_o;
  assign pop_o  = ack_i && irq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= HS_FREE;
    else if (pop_o) st_q <= HS_BUSY;
    else if (ret_i) st_q <= HS_FREE;
  end
endmodule

// File: rtl/irq_fifo_queue.sv
module irq_fifo_queue #(
  parameter int N_SRC = 4,
  parameter int DEPTH = 8,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic             irq_o,
  output logic [SRC_W-1:0] irq_id_o,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             ovf_o,
  input  logic             ovf_clr_i
);
  logic             wr_valid, empty, full, pop, busy;
  logic [SRC_W-1:0] wr_id;

  irqq_capture #(.N_SRC(N_SRC)) u_cap (
    .clk_i, .rst_ni, .req_i, .wr_valid_o(wr_valid), .wr_id_o(wr_id)
  );

  irqq_ring #(.DEPTH(DEPTH), .SRC_W(SRC_W)) u_ring (
    .clk_i, .rst_ni, .wr_valid_i(wr_valid), .wr_id_i(wr_id), .pop_i(pop),
    .ovf_clr_i, .head_o(irq_id_o), .empty_o(empty), .full_o(full), .ovf_o
  );

  irqq_deliver u_dlv (
    .clk_i, .rst_ni, .empty_i(empty), .ack_i, .ret_i,
    .irq_o, .pop_o(pop), .busy_o(busy)
  );
endmodule

// File: rtl/irqq_chk.sv
module irqq_chk #(
  parameter int SRC_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [SRC_W-1:0] irq_id_o,
  input logic             ack_i,
  input logic             ret_i,
  input logic             ovf_o,
  input logic             ovf_clr_i,
  input logic             full,
  input logic             empty,
  input logic             busy,
  input logic             wr_valid
);
  // R6
  ack_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);
  // R8
  head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> $stable(irq_id_o));
  // R7
  ret_redeliver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ret_i && !empty) |=> irq_o);
  // R9
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(full && wr_valid));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R5
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty || busy) |-> !irq_o);
endmodule

bind irq_fifo_queue irqq_chk #(.SRC_W(SRC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .irq_id_o(irq_id_o),
  .ack_i(ack_i), .ret_i(ret_i), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i),
  .full(full), .empty(empty), .busy(busy), .wr_valid(wr_valid)
);

// File: tb/irq_fifo_queue_test.sv
`timescale 1ns/1ps
module irq_fifo_queue_test;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic ack = 1'b0, ret = 1'b0, clr = 1'b0;
  logic irq, ovf;
  logic [W-1:0] id;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_fifo_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .irq_o(irq), .irq_id_o(id),
    .ack_i(ack), .ret_i(ret), .ovf_o(ovf), .ovf_clr_i(clr)
  );

  // {mask, expected entry count}
  localparam logic [7:0] VEC [6] = '{
    {4'b0001, 4'd1}, {4'b1010, 4'd2}, {4'b1111, 4'd4},
    {4'b0110, 4'd2}, {4'b1000, 4'd1}, {4'b0101, 4'd2}
  };

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  // at a negedge: expects irq with id, takes it, returns
  task automatic serve(input int exp_id, input string r);
    chk(irq === 1'b1, r, int'(irq), 1);
    chk(id === W'(exp_id), r, int'(id), exp_id);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(irq === 1'b0, "R6", int'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b0, "R6", int'(irq), 0);
    ret = 1'b1; @(negedge clk); ret = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; @(negedge clk);
    chk(irq === 1'b0, "R1", int'(irq), 0);
    chk(ovf === 1'b0, "R1", int'(ovf), 0);

    // table walk: R2, R3, R5
    for (int v = 0; v < 6; v++) begin
      int n;
      n = 0;
      pulse(VEC[v][7:4]);
      cyc(5);
      for (int k = 0; k < N; k++) begin
        if (VEC[v][4+k]) begin
          serve(k, "R3");
          n++;
        end
      end
      chk(irq === 1'b0, "R2", int'(irq), 0);
      chk(n == int'(VEC[v][3:0]), "R2", n, int'(VEC[v][3:0]));
    end

    // R5 latency: visible one edge after the rise
    @(negedge clk); req = 4'b0100;
    @(negedge clk);
    chk(irq === 1'b1, "R5", int'(irq), 1);
    chk(id === 2'd2, "R5", int'(id), 2);
    req = '0;
    serve(2, "R5");

    // R2 held-high line logs once
    @(negedge clk); req = 4'b0010;
    cyc(6); req = '0; cyc(2);
    serve(1, "R2");
    chk(irq === 1'b0, "R2", int'(irq), 0);

    // R4 arrival order beats index; R7 immediate re-delivery
    pulse(4'b1000); cyc(2); pulse(4'b0001); cyc(2);
    serve(3, "R4");
    chk(irq === 1'b1, "R7", int'(irq), 1);
    serve(0, "R4");

    // R11 stray ack ignored
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    pulse(4'b0010); cyc(1);
    serve(1, "R11");

    // R9 overflow: 12 requests into 8 slots
    pulse(4'b1111); cyc(5);
    pulse(4'b1111); cyc(5);
    chk(ovf === 1'b0, "R9", int'(ovf), 0);
    pulse(4'b1111); cyc(5);
    chk(ovf === 1'b1, "R9", int'(ovf), 1);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < N; k++) serve(k, "R9");
    chk(irq === 1'b0, "R9", int'(irq), 0);
    chk(ovf === 1'b1, "R9", int'(ovf), 1);

    // R10 clear
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(ovf === 1'b0, "R10", int'(ovf), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule